// File: doc/BRIEF.md
# Multi-Line Ultrasound Acquisition Sequencer

This block paces a burst of ultrasound receive lines. A start request, taken while the block is idle, launches a burst whose length comes from a line-count field holding the number of lines minus one. Each line opens with a single-cycle line-start strobe, which the pulser and the gain sequencer use as their time origin. A fixed sampling window of 2^SAMPLE_BITS samples then follows, 16384 by default: 256 µs at 64 MSPS. The block runs from a clock at twice the sample rate, 128 MHz, and raises a sample-valid pulse on every second cycle. Each pulse carries a capture-buffer address.

The address is the line index placed above the sample index. A capture memory can therefore write each line into its own region with no further arithmetic. A done flag is low from the cycle after a start is accepted until the last line has ended. In double-rate mode, lines with an odd index sample one fast-clock cycle later than lines with an even index. Two consecutive lines can then be merged into one record at twice the sample rate. Line 0 counts as even.

The line count and the mode are captured when a burst is launched. Changes to them while a burst runs take no effect. The sample stream is a valid-only stream with no back-pressure: the capture buffer must take every pulse in the cycle it appears, because the analog sampling instant cannot be delayed.

Top module: `acq_burst_ctrl`

## Requirements
- R1: After reset and whenever no burst runs, done_o is 1 and both line_start_o and smp_valid_o are 0.
- R2: When start_i is 1 at a clock edge while done_o is 1, done_o is 0 in the next cycle. line_start_o is 1 in that same cycle, for exactly one cycle.
- R3: A burst contains exactly line_cnt_m1_i + 1 lines, with line_cnt_m1_i taken at the accepting edge (0 gives one line, all ones gives 2^LINE_BITS lines).
- R4: Each line takes 1 + 2·2^SAMPLE_BITS cycles: one strobe cycle, then 2^SAMPLE_BITS sample slots of two cycles each. smp_valid_o is 1 in exactly one cycle of each slot and is never 1 in two consecutive cycles.
- R5: While smp_valid_o is 1, smp_addr_o equals line_index·2^SAMPLE_BITS + sample_index. line_index starts at 0 and sample_index runs from 0 upward within each line.
- R6: done_o returns to 1 in the cycle after the last cycle of the last line, and the next line-start strobe of a burst follows directly after the last slot of the line before it.
- R7: With dual_rate_i taken as 0 at launch, smp_valid_o is in the first cycle of each slot for every line. With it taken as 1, even lines (line 0 included) use the first cycle and odd lines use the second cycle.
- R8: While done_o is 0, start_i has no effect, and changes to line_cnt_m1_i or dual_rate_i do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request, accepted only while idle |
| line_cnt_m1_i | input | LINE_BITS | Number of lines in the burst minus one |
| dual_rate_i | input | 1 | Offset odd lines by one fast-clock cycle |
| line_start_o | output | 1 | One-cycle strobe at the start of each line |
| smp_valid_o | output | 1 | Sample-enable pulse (valid, no ready) |
| smp_addr_o | output | LINE_BITS+SAMPLE_BITS | Capture address {line, sample} |
| done_o | output | 1 | 1 when idle, 0 while a burst runs |

## Verification
Counting from the edge that accepts start_i, the strobe and the falling done flag are due one cycle later. The first even-line sample is due two cycles later, or three cycles later for an odd line in double-rate mode. Each later line is due 1 + 2·2^SAMPLE_BITS cycles after the one before, and done is due high one cycle after the final slot. The driver turns each launch into a cycle-by-cycle list of expected strobe, valid, address and done values and queues it. The monitor takes one entry per clock, 1 ns after the rising edge, so each comparison falls exactly in the cycle where the entry is due. When the queue is empty, the monitor checks the idle values instead. Starts and configuration changes are injected mid-burst, and the queue is left unchanged for them.

// File: rtl/acq_burst_pkg.sv
package acq_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_SAMPLE = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_cfg_latch.sv
module acq_cfg_latch #(
  parameter int LINE_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_i,
  input  logic [LINE_BITS-1:0] nlast_i,
  input  logic                 dual_i,
  output logic [LINE_BITS-1:0] nlast_o,
  output logic                 dual_o
);
  // Burst configuration is frozen at launch so mid-burst writes are inert.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nlast_o <= '0;
      dual_o  <= 1'b0;
    end else if (launch_i) begin
      nlast_o <= nlast_i;
      dual_o  <= dual_i;
    end
  end
endmodule

// File: rtl/acq_sample_pacer.sv
module acq_sample_pacer #(
  parameter int SAMPLE_BITS = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   late_i,
  output logic                   fire_o,
  output logic                   last_o,
  output logic [SAMPLE_BITS-1:0] sidx_o
);
  localparam logic [SAMPLE_BITS-1:0] SIDX_LAST = {SAMPLE_BITS{1'b1}};

  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      phase  <= 1'b0;
      sidx_o <= '0;
    end else begin
      phase <= ~phase;
      if (phase) sidx_o <= sidx_o + SAMPLE_BITS'(1);
    end
  end

  assign fire_o = run_i && (phase == late_i);
  assign last_o = run_i && phase && (sidx_o == SIDX_LAST);

  AST_FIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R4
endmodule

// File: rtl/acq_line_fsm.sv
module acq_line_fsm
  import acq_burst_pkg::*;
#(
  parameter int LINE_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LINE_BITS-1:0] nlast_i,
  input  logic                 line_end_i,
  output logic                 launch_o,
  output logic [LINE_BITS-1:0] line_o,
  output logic                 strobe_o,
  output logic                 run_o,
  output logic                 done_o
);
  acq_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      line_o <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state  <= ST_STROBE;
          line_o <= '0;
        end
        ST_STROBE: state <= ST_SAMPLE;
        ST_SAMPLE: if (line_end_i) begin
          if (line_o == nlast_i) begin
            state <= ST_IDLE;
          end else begin
            line_o <= line_o + LINE_BITS'(1);
            state  <= ST_STROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign launch_o = (state == ST_IDLE) && start_i;
  assign strobe_o = (state == ST_STROBE);
  assign run_o    = (state == ST_SAMPLE);
  assign done_o   = (state == ST_IDLE);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R2
  AST_LAST_LINE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && line_end_i && line_o == nlast_i) |=> done_o); // R6
  AST_NEXT_LINE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && line_end_i && line_o != nlast_i) |=> strobe_o); // R6
endmodule

// File: rtl/acq_burst_ctrl.sv
module acq_burst_ctrl #(
  parameter int LINE_BITS   = 5,
  parameter int SAMPLE_BITS = 14,
  localparam int ADDR_BITS  = LINE_BITS + SAMPLE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LINE_BITS-1:0] line_cnt_m1_i,
  input  logic                 dual_rate_i,
  output logic                 line_start_o,
  output logic                 smp_valid_o,
  output logic [ADDR_BITS-1:0] smp_addr_o,
  output logic                 done_o
);
  logic                   launch;
  logic [LINE_BITS-1:0]   nlast_q;
  logic                   dual_q;
  logic [LINE_BITS-1:0]   line_idx;
  logic                   run;
  logic                   line_end;
  logic                   late;
  logic [SAMPLE_BITS-1:0] sidx;

  acq_cfg_latch #(.LINE_BITS(LINE_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .launch_i(launch),
    .nlast_i(line_cnt_m1_i), .dual_i(dual_rate_i),
    .nlast_o(nlast_q), .dual_o(dual_q)
  );

  acq_line_fsm #(.LINE_BITS(LINE_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nlast_i(nlast_q),
    .line_end_i(line_end), .launch_o(launch), .line_o(line_idx),
    .strobe_o(line_start_o), .run_o(run), .done_o(done_o)
  );

  // Odd lines in double-rate mode take the second cycle of each slot.
  assign late = dual_q && line_idx[0];

  acq_sample_pacer #(.SAMPLE_BITS(SAMPLE_BITS)) u_pace (
    .clk(clk), .rst_n(rst_n), .run_i(run), .late_i(late),
    .fire_o(smp_valid_o), .last_o(line_end), .sidx_o(sidx)
  );

  assign smp_addr_o = {line_idx, sidx};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!smp_valid_o && !line_start_o)); // R1
  AST_LAUNCH_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (!done_o && line_start_o)); // R2
  AST_FIRST_SLOT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |=> (smp_valid_o == !(dual_q && line_idx[0]))); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && start_i && !line_end) |=> !line_start_o); // R8
endmodule

// File: tb/acq_burst_ctrl_tb.sv
module acq_burst_ctrl_tb;
  localparam int LB = 3;
  localparam int SB = 3;
  localparam int AW = LB + SB;
  localparam int NS = 1 << SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LB-1:0] cnt_i = '0;
  logic          dual_i = 1'b0;
  logic          line_start_o, smp_valid_o, done_o;
  logic [AW-1:0] smp_addr_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;

  // Expected entry: {strobe, valid, done, addr}
  logic [AW+2:0] exp_q[$];
  logic [AW+2:0] e;

  always #2 clk = ~clk;

  acq_burst_ctrl #(.LINE_BITS(LB), .SAMPLE_BITS(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_cnt_m1_i(cnt_i),
    .dual_rate_i(dual_i), .line_start_o(line_start_o),
    .smp_valid_o(smp_valid_o), .smp_addr_o(smp_addr_o), .done_o(done_o)
  );

  task automatic chk(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, expv, $time);
    end
  endtask

  // Monitor: one comparison set per cycle, 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(line_start_o, e[AW+2], "R2 line_start");
        chk(smp_valid_o, e[AW+1], "R4 R7 smp_valid");
        chk(done_o, e[AW], "R3 R6 done");
        if (e[AW+1]) begin
          checks++;
          if (smp_addr_o !== e[AW-1:0]) begin
            errors++;
            $display("FAIL R5 addr actual=%0d expected=%0d", smp_addr_o, e[AW-1:0]);
          end
        end
      end else begin
        chk(done_o, 1'b1, "R1 idle done");
        chk(line_start_o, 1'b0, "R1 idle strobe");
        chk(smp_valid_o, 1'b0, "R1 idle valid");
      end
    end
  end

  // Driver: launch a burst and queue its expected cycle-by-cycle outputs.
  task automatic run_burst(input int nm1, input bit dual, input bit poke);
    @(negedge clk);
    cnt_i = LB'(nm1);
    dual_i = dual;
    start_i = 1'b1;
    for (int l = 0; l <= nm1; l++) begin
      exp_q.push_back({1'b1, 1'b0, 1'b0, AW'(0)});
      for (int k = 0; k < 2 * NS; k++) begin
        bit late = dual && l[0];
        bit v = ((k % 2) == int'(late));
        exp_q.push_back({1'b0, v, 1'b0, AW'(l * NS + k / 2)});
      end
    end
    exp_q.push_back({1'b0, 1'b0, 1'b1, AW'(0)}); // R6 done back high
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R8: scramble configuration while busy
      cnt_i = ~LB'(nm1);
      dual_i = ~dual;
    end
    for (int t = 0; exp_q.size() > 0; t++) begin
      @(negedge clk);
      start_i = poke && (t == 5 || t == 6 || t == 20 || t == 34);
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o, 1'b1, "R1 reset done");
    chk(line_start_o, 1'b0, "R1 reset strobe");
    chk(smp_valid_o, 1'b0, "R1 reset valid");
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    run_burst(0, 1'b0, 1'b0);   // R3 single line
    run_burst(2, 1'b1, 1'b0);   // R7 even/odd/even
    run_burst(3, 1'b0, 1'b1);   // R8 mid-burst start and config changes
    run_burst(7, 1'b1, 1'b0);   // R3 R5 full line range
    run_burst(1, 1'b0, 1'b0);   // R7 no offset on odd line
    mon_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule